// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the wire-level master for a two-wire debug link. Given one command it runs a complete register access on the far end: it sends the eight-bit request header, lets go of the data line for the turnaround, and collects the three-bit acknowledge. For a read it then shifts in a 32-bit word and its parity bit. For a write it shifts out a 32-bit word and its parity bit. The serial clock is derived from the system clock. The bidirectional data line is handled through three separate signals: a value to drive, a drive enable, and the value seen on the pin.

When a write changes the line from target-driven to host-driven, the block places data bit 0 on its output register during the second turnaround slot, while the enable is still low. When the enable rises, the pin therefore moves straight from released to its final level, with no intermediate value. On request the engine can also send a line-reset pattern in place of a transaction, and it can append a run of idle slots after any frame so that the last access is clocked through. Each command is framed by busy and a one-cycle done pulse.

Top module: `swd_host_engine`

## Requirements
- R1: A transaction begins with eight host-driven slots (enable high), LSB first: bit0 start = 1, bit1 port select (1 = access port), bit2 read select, bit3 addr[0], bit4 addr[1], bit5 even parity of bits 1..4, bit6 stop = 0, bit7 park = 1.
- R2: After the header, the enable is low for one turnaround slot and for the three acknowledge slots. The acknowledge is sampled LSB first and reported raw on ack_o.
- R3: On a read, 32 data bits (LSB first) and then one parity bit are sampled with the enable low, followed by one more released turnaround slot, for 46 slots in total. The word is reported on rdata_o.
- R4: par_err_o is 1 after a read whose parity bit does not equal the even parity of the 32 data bits, and 0 after any other read or write.
- R5: On a write, slot 12 is a released turnaround in which swdio_o already carries data bit 0. Slots 13 to 45 are driven with the 32 data bits LSB first, followed by their even parity.
- R6: In the clock cycle in which the drive enable rises for write data, swdio_o does not change.
- R7: ack_class_o reports 0 for an acknowledge of 3'b001, 1 for 3'b010, 2 for 3'b100, and 3 for any other code.
- R8: With idle_i set at start, IDLE_LEN extra slots follow the frame, driven low with the enable high.
- R9: With lrst_i set at start, the frame is LRST_LEN slots driven high with the enable high (plus the idle tail if requested). ack_o, rdata_o and par_err_o keep their previous values.
- R10: swdio_o and swdio_oe_o change only while swclk_o is low. The input is sampled on the rising edge of swclk_o.
- R11: start_i is taken only while busy_o is low; a start while busy has no effect. done_o pulses for one cycle when the frame ends. swclk_o stays low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a frame (taken when idle) |
| rnw_i | input | 1 | 1 = read, 0 = write |
| apndp_i | input | 1 | 1 = access port, 0 = debug port |
| addr_i | input | 2 | Register address bits [3:2] |
| wdata_i | input | 32 | Write word |
| lrst_i | input | 1 | Send the line-reset pattern instead of a transaction |
| idle_i | input | 1 | Append idle slots after the frame |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 32 | Last read word |
| ack_o | output | 3 | Last acknowledge, raw |
| ack_class_o | output | 2 | Acknowledge class: 0 OK, 1 WAIT, 2 FAULT, 3 invalid |
| par_err_o | output | 1 | Read parity mismatch |
| swclk_o | output | 1 | Serial clock |
| swdio_o | output | 1 | Value to drive on the data line |
| swdio_oe_o | output | 1 | Drive enable for the data line |
| swdio_i | input | 1 | Value seen on the data line |

## Verification
The bench builds the engine with HALF_DIV = 2, LRST_LEN = 52 and IDLE_LEN = 8. With HALF_DIV = 2, each half period of the serial clock lasts several system cycles, so the rule that the outputs stay still while the clock is high is tested over more than a single edge. A line-reset length above the minimum confirms that the slot counter runs to its parameter rather than to a fixed value. An idle tail of eight slots makes the write-plus-idle and reset-plus-idle frames exercise the change from a body state into the tail state.

// File: rtl/swd_host_pkg.sv
`timescale 1ns/1ps
package swd_host_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ACK_W  = 3;
  localparam int unsigned REQ_W  = 8;

  typedef enum logic [1:0] {
    ACK_IS_OK    = 2'd0,
    ACK_IS_WAIT  = 2'd1,
    ACK_IS_FAULT = 2'd2,
    ACK_IS_BAD   = 2'd3
  } ack_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_TRN_A, ST_ACK, ST_RD, ST_TRN_R,
    ST_TRN_W, ST_WR, ST_LRST, ST_TAIL
  } seq_state_e;

  // even parity of a data word
  function automatic logic word_parity(input logic [WORD_W-1:0] w);
    return ^w;
  endfunction

  // header, LSB first: start, port, read, a0, a1, parity, stop, park
  function automatic logic [REQ_W-1:0] build_request(input logic port_sel,
                                                     input logic rd,
                                                     input logic [1:0] a);
    logic p;
    p = port_sel ^ rd ^ a[0] ^ a[1];
    return {1'b1, 1'b0, p, a[1], a[0], rd, port_sel, 1'b1};
  endfunction

  function automatic ack_kind_e classify_ack(input logic [ACK_W-1:0] code);
    case (code)
      3'b001:  return ACK_IS_OK;
      3'b010:  return ACK_IS_WAIT;
      3'b100:  return ACK_IS_FAULT;
      default: return ACK_IS_BAD;
    endcase
  endfunction
endpackage

// File: rtl/swd_clk_phase.sv
`timescale 1ns/1ps
module swd_clk_phase #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic swclk_o,
  output logic sample_o,
  output logic slot_end_o
);
  localparam int unsigned PER  = 2 * HALF_DIV;
  localparam int unsigned PH_W = (PER > 2) ? $clog2(PER) : 1;

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ph_q <= '0;
    else if (!run_i)                  ph_q <= '0;
    else if (ph_q == PH_W'(PER - 1))  ph_q <= '0;
    else                              ph_q <= ph_q + 1'b1;
  end

  // low half first, so every slot opens with a falling edge
  assign swclk_o    = run_i && (ph_q >= PH_W'(HALF_DIV));
  assign sample_o   = run_i && (ph_q == PH_W'(HALF_DIV - 1));
  assign slot_end_o = run_i && (ph_q == PH_W'(PER - 1));

  // R10
  rise_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> swclk_o);
endmodule

// File: rtl/swd_ack_classify.sv
`timescale 1ns/1ps
module swd_ack_classify
  import swd_host_pkg::*;
(
  input  logic [ACK_W-1:0] code_i,
  output ack_kind_e        kind_o
);
  assign kind_o = classify_ack(code_i);

  // R7
  always_comb begin
    if ($onehot(code_i) && (code_i != 3'b000) && !code_i[ACK_W-1] && !code_i[0])
      wait_code_chk: assert (kind_o == ACK_IS_WAIT);
  end
endmodule

// File: rtl/swd_frame_seq.sv
`timescale 1ns/1ps
module swd_frame_seq
  import swd_host_pkg::*;
#(
  parameter int unsigned LRST_LEN = 50,
  parameter int unsigned IDLE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rnw_i,
  input  logic              apndp_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              lrst_i,
  input  logic              idle_i,
  input  logic              sample_i,
  input  logic              slot_end_i,
  input  logic              swdio_i,
  output logic              run_o,
  output logic              done_o,
  output logic              sdo_o,
  output logic              oe_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [ACK_W-1:0]  ack_o,
  output logic              par_err_o
);
  localparam int unsigned CNT_MAX = (LRST_LEN > WORD_W + 1)
                                    ? ((LRST_LEN > IDLE_LEN) ? LRST_LEN : IDLE_LEN)
                                    : ((WORD_W + 1 > IDLE_LEN) ? WORD_W + 1 : IDLE_LEN);
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q, done_q, sdo_q, oe_q;
  logic              rnw_q, lrst_q, tail_q;
  logic [WORD_W-1:0] wd_q;
  logic [WORD_W:0]   out_sr;
  logic [WORD_W:0]   rx_sr;
  logic [ACK_W-1:0]  ack_sr;
  logic [WORD_W-1:0] rdata_q;
  logic [ACK_W-1:0]  ack_q;
  logic              perr_q;

  // named slot events
  logic req_last, ack_last, rd_last, body_last, tail_last;
  assign req_last  = (state_q == ST_REQ) && (cnt_q == CNT_W'(REQ_W - 1));
  assign ack_last  = (state_q == ST_ACK) && (cnt_q == CNT_W'(ACK_W - 1));
  assign rd_last   = (state_q == ST_RD)  && (cnt_q == CNT_W'(WORD_W));
  assign body_last = (state_q == ST_TRN_R)
                  || ((state_q == ST_WR)   && (cnt_q == CNT_W'(WORD_W)))
                  || ((state_q == ST_LRST) && (cnt_q == CNT_W'(LRST_LEN - 1)));
  assign tail_last = (state_q == ST_TAIL) && (cnt_q == CNT_W'(IDLE_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      rnw_q   <= 1'b0;
      lrst_q  <= 1'b0;
      tail_q  <= 1'b0;
      wd_q    <= '0;
      out_sr  <= '0;
      rx_sr   <= '0;
      ack_sr  <= '0;
      rdata_q <= '0;
      ack_q   <= '0;
      perr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sample_i) begin
        if (state_q == ST_ACK) ack_sr <= {swdio_i, ack_sr[ACK_W-1:1]};
        if (state_q == ST_RD)  rx_sr  <= {swdio_i, rx_sr[WORD_W:1]};
      end
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          rnw_q  <= rnw_i;
          lrst_q <= lrst_i;
          tail_q <= idle_i;
          wd_q   <= wdata_i;
          out_sr <= {{(WORD_W + 1 - REQ_W){1'b0}}, build_request(apndp_i, rnw_i, addr_i)};
          sdo_q  <= 1'b1;            // header start bit and reset level are both high
          oe_q   <= 1'b1;
          run_q  <= 1'b1;
          cnt_q  <= '0;
          state_q <= lrst_i ? ST_LRST : ST_REQ;
        end
      end else if (slot_end_i) begin
        if (body_last && tail_q) begin
          state_q <= ST_TAIL;
          cnt_q   <= '0;
          sdo_q   <= 1'b0;
          oe_q    <= 1'b1;
        end else if (body_last || tail_last) begin
          state_q <= ST_IDLE;
          run_q   <= 1'b0;
          done_q  <= 1'b1;
          sdo_q   <= 1'b0;
          oe_q    <= 1'b0;
          if (!lrst_q) begin
            ack_q <= ack_sr;
            if (rnw_q) begin
              rdata_q <= rx_sr[WORD_W-1:0];
              perr_q  <= rx_sr[WORD_W] != word_parity(rx_sr[WORD_W-1:0]);
            end else begin
              perr_q  <= 1'b0;
            end
          end
        end else begin
          case (state_q)
            ST_REQ: begin
              if (req_last) begin
                state_q <= ST_TRN_A;
                cnt_q   <= '0;
                oe_q    <= 1'b0;
                sdo_q   <= 1'b0;
              end else begin
                cnt_q  <= cnt_q + 1'b1;
                out_sr <= out_sr >> 1;
                sdo_q  <= out_sr[1];
              end
            end
            ST_TRN_A: begin
              state_q <= ST_ACK;
              cnt_q   <= '0;
            end
            ST_ACK: begin
              if (ack_last) begin
                cnt_q <= '0;
                if (rnw_q) begin
                  state_q <= ST_RD;
                end else begin
                  // preload bit 0 while the line is still released
                  state_q <= ST_TRN_W;
                  out_sr  <= {word_parity(wd_q), wd_q};
                  sdo_q   <= wd_q[0];
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            ST_RD: begin
              if (rd_last) begin
                state_q <= ST_TRN_R;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            ST_TRN_W: begin
              state_q <= ST_WR;
              cnt_q   <= '0;
              oe_q    <= 1'b1;
            end
            ST_WR: begin
              cnt_q  <= cnt_q + 1'b1;
              out_sr <= out_sr >> 1;
              sdo_q  <= out_sr[1];
            end
            ST_LRST, ST_TAIL: cnt_q <= cnt_q + 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assign run_o     = run_q;
  assign done_o    = done_q;
  assign sdo_o     = sdo_q;
  assign oe_o      = oe_q;
  assign rdata_o   = rdata_q;
  assign ack_o     = ack_q;
  assign par_err_o = perr_q;

  // R2
  ack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRN_A || state_q == ST_ACK) |-> !oe_q);
  // R3
  read_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD || state_q == ST_TRN_R) |-> !oe_q);
  // R5
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRN_W) |-> (!oe_q && (sdo_q == wd_q[0])));
  // R6
  no_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_q) && state_q == ST_WR) |-> $stable(sdo_q));
  // R8
  tail_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |-> (oe_q && !sdo_q));
  // R9
  reset_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LRST) |-> (oe_q && sdo_q));
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start_i && !slot_end_i) |=> run_q);
endmodule

// File: rtl/swd_host_engine.sv
`timescale 1ns/1ps
module swd_host_engine
  import swd_host_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned LRST_LEN = 50,
  parameter int unsigned IDLE_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rnw_i,
  input  logic        apndp_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        lrst_i,
  input  logic        idle_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] rdata_o,
  output logic [2:0]  ack_o,
  output logic [1:0]  ack_class_o,
  output logic        par_err_o,
  output logic        swclk_o,
  output logic        swdio_o,
  output logic        swdio_oe_o,
  input  logic        swdio_i
);
  logic      run_w, sample_w, slot_end_w;
  ack_kind_e kind_w;

  swd_clk_phase #(.HALF_DIV(HALF_DIV)) clk_phase_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_w),
    .swclk_o    (swclk_o),
    .sample_o   (sample_w),
    .slot_end_o (slot_end_w)
  );

  swd_frame_seq #(.LRST_LEN(LRST_LEN), .IDLE_LEN(IDLE_LEN)) frame_seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rnw_i      (rnw_i),
    .apndp_i    (apndp_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .lrst_i     (lrst_i),
    .idle_i     (idle_i),
    .sample_i   (sample_w),
    .slot_end_i (slot_end_w),
    .swdio_i    (swdio_i),
    .run_o      (run_w),
    .done_o     (done_o),
    .sdo_o      (swdio_o),
    .oe_o       (swdio_oe_o),
    .rdata_o    (rdata_o),
    .ack_o      (ack_o),
    .par_err_o  (par_err_o)
  );

  swd_ack_classify ack_cls_i (
    .code_i (ack_o),
    .kind_o (kind_w)
  );

  assign ack_class_o = kind_w;
  assign busy_o      = run_w;

  // R10
  quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swclk_o |-> ($stable(swdio_o) && $stable(swdio_oe_o)));
  // R11
  clock_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !swclk_o);
endmodule

// File: tb/swd_host_engine_tb.sv
`timescale 1ns/1ps
module swd_host_engine_tb_top;
  localparam int HALF = 2;
  localparam int LRST_N = 52;
  localparam int IDLE_N = 8;

  logic clk, rst_n;
  logic start, rnw, apndp, lrst, idle;
  logic [1:0] addr;
  logic [31:0] wdata;
  logic busy, done;
  logic [31:0] rdata;
  logic [2:0] ack;
  logic [1:0] ack_cls;
  logic perr, swclk, sdo, oe, sdi;

  swd_host_engine #(.HALF_DIV(HALF), .LRST_LEN(LRST_N), .IDLE_LEN(IDLE_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rnw_i(rnw), .apndp_i(apndp),
    .addr_i(addr), .wdata_i(wdata), .lrst_i(lrst), .idle_i(idle),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .ack_o(ack),
    .ack_class_o(ack_cls), .par_err_o(perr), .swclk_o(swclk),
    .swdio_o(sdo), .swdio_oe_o(oe), .swdio_i(sdi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // target model state
  logic [2:0]  tgt_ack;
  logic [31:0] tgt_data;
  logic        tgt_rd, tgt_flip;
  int r = 0;
  logic obs_sdo [0:127];
  logic obs_oe  [0:127];

  always @(posedge swclk) begin
    if (r < 128) begin
      obs_sdo[r] = sdo;
      obs_oe[r]  = oe;
    end
    r = r + 1;
  end

  always_comb begin
    sdi = 1'b1;
    if (r >= 9 && r <= 11) sdi = tgt_ack[r-9];
    else if (tgt_rd && r >= 12 && r <= 43) sdi = tgt_data[r-12];
    else if (tgt_rd && r == 44) sdi = (^tgt_data) ^ tgt_flip;
  end

  // port monitors
  int rise_cnt = 0, done_cnt = 0, hi_moves = 0;
  logic p_oe = 1'b0, p_sdo = 1'b0, p_clk = 1'b0;
  logic rise_prev, rise_new;
  always @(negedge clk) begin
    if (!p_oe && oe) begin
      rise_cnt  = rise_cnt + 1;
      rise_prev = p_sdo;
      rise_new  = sdo;
    end
    if (p_clk && swclk && (p_sdo !== sdo || p_oe !== oe)) hi_moves = hi_moves + 1;
    if (done) done_cnt = done_cnt + 1;
    p_oe = oe; p_sdo = sdo; p_clk = swclk;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_header(input logic ap, input logic rd, input logic [1:0] a);
    logic [7:0] b;
    int ones;
    ones = int'(ap) + int'(rd) + int'(a[0]) + int'(a[1]);
    b[0] = 1'b1; b[1] = ap; b[2] = rd; b[3] = a[0]; b[4] = a[1];
    b[5] = (ones % 2) == 1; b[6] = 1'b0; b[7] = 1'b1;
    return b;
  endfunction

  function automatic logic [1:0] exp_class(input logic [2:0] c);
    if (c == 3'd1) return 2'd0;
    if (c == 3'd2) return 2'd1;
    if (c == 3'd4) return 2'd2;
    return 2'd3;
  endfunction

  task automatic run_frame(input logic rd, input logic ap, input logic [1:0] a,
                           input logic [31:0] wd, input logic id, input logic lr,
                           input logic bump);
    int guard;
    @(negedge clk);
    r = 0; rise_cnt = 0; done_cnt = 0; hi_moves = 0;
    tgt_rd = rd && !lr;
    rnw = rd; apndp = ap; addr = a; wdata = wd; idle = id; lrst = lr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bump) begin
      repeat (40) @(negedge clk);
      start = 1'b1; lrst = 1'b1; rnw = ~rd; wdata = ~wd;
      @(negedge clk);
      start = 1'b0; lrst = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_header(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    int drv;
    drv = 0;
    for (int i = 0; i < 8; i++) begin
      got[i] = obs_sdo[i];
      if (obs_oe[i]) drv++;
    end
    chk({tag, " R1 header bits"}, 64'(got), 64'(exp));
    chk({tag, " R1 header driven"}, 64'(drv), 64'd8);
  endtask

  task automatic check_tail(input string tag, input int first);
    int bad;
    bad = 0;
    for (int i = first; i < first + IDLE_N; i++)
      if (obs_oe[i] !== 1'b1 || obs_sdo[i] !== 1'b0) bad++;
    chk({tag, " R8 idle slots"}, 64'(bad), 64'd0);
  endtask

  task automatic test_read(input string tag, input logic ap, input logic [1:0] a,
                           input logic [31:0] d, input logic [2:0] ak,
                           input logic flip, input logic id, input logic bump);
    int drv;
    tgt_ack = ak; tgt_data = d; tgt_flip = flip;
    run_frame(1'b1, ap, a, 32'h0, id, 1'b0, bump);
    check_header(tag, exp_header(ap, 1'b1, a));
    drv = 0;
    for (int i = 8; i < 12; i++) if (obs_oe[i]) drv++;
    chk({tag, " R2 released for ack"}, 64'(drv), 64'd0);
    chk({tag, " R2 ack value"}, 64'(ack), 64'(ak));
    drv = 0;
    for (int i = 12; i < 46; i++) if (obs_oe[i]) drv++;
    chk({tag, " R3 released for data"}, 64'(drv), 64'd0);
    chk({tag, " R3 read word"}, 64'(rdata), 64'(d));
    chk({tag, " R4 parity flag"}, 64'(perr), 64'(flip));
    chk({tag, " R7 ack class"}, 64'(ack_cls), 64'(exp_class(ak)));
    chk({tag, " R3 slot count"}, 64'(r), 64'(46 + (id ? IDLE_N : 0)));
    chk({tag, " R11 one done"}, 64'(done_cnt), 64'd1);
    chk({tag, " R11 idle after"}, 64'({busy, swclk}), 64'd0);
    chk({tag, " R10 still while high"}, 64'(hi_moves), 64'd0);
    if (id) check_tail(tag, 46);
  endtask

  task automatic test_write(input string tag, input logic ap, input logic [1:0] a,
                            input logic [31:0] d, input logic [2:0] ak, input logic id);
    logic [32:0] got;
    int drv;
    tgt_ack = ak; tgt_data = 32'h0; tgt_flip = 1'b0;
    run_frame(1'b0, ap, a, d, id, 1'b0, 1'b0);
    check_header(tag, exp_header(ap, 1'b0, a));
    chk({tag, " R5 turnaround released"}, 64'(obs_oe[12]), 64'd0);
    chk({tag, " R5 bit0 preloaded"}, 64'(obs_sdo[12]), 64'(d[0]));
    drv = 0;
    for (int i = 0; i < 33; i++) begin
      got[i] = obs_sdo[13 + i];
      if (obs_oe[13 + i]) drv++;
    end
    chk({tag, " R5 data and parity"}, 64'(got), 64'({^d, d}));
    chk({tag, " R5 data driven"}, 64'(drv), 64'd33);
    chk({tag, " R6 enable rises"}, 64'(rise_cnt), 64'd2);
    chk({tag, " R6 level at takeover"}, 64'({rise_prev, rise_new}), 64'({d[0], d[0]}));
    chk({tag, " R4 no flag on write"}, 64'(perr), 64'd0);
    chk({tag, " R7 ack class"}, 64'(ack_cls), 64'(exp_class(ak)));
    chk({tag, " R5 slot count"}, 64'(r), 64'(46 + (id ? IDLE_N : 0)));
    chk({tag, " R10 still while high"}, 64'(hi_moves), 64'd0);
    if (id) check_tail(tag, 46);
  endtask

  task automatic test_lrst(input string tag, input logic id);
    logic [2:0]  old_ack;
    logic [31:0] old_rd;
    logic        old_pe;
    int bad;
    old_ack = ack; old_rd = rdata; old_pe = perr;
    tgt_ack = 3'b001;
    run_frame(1'b1, 1'b0, 2'd0, 32'h0, id, 1'b1, 1'b0);
    bad = 0;
    for (int i = 0; i < LRST_N; i++)
      if (obs_oe[i] !== 1'b1 || obs_sdo[i] !== 1'b1) bad++;
    chk({tag, " R9 reset pattern"}, 64'(bad), 64'd0);
    chk({tag, " R9 slot count"}, 64'(r), 64'(LRST_N + (id ? IDLE_N : 0)));
    chk({tag, " R9 results kept"}, {29'd0, old_ack, old_rd}, {29'd0, ack, rdata});
    chk({tag, " R9 parity flag kept"}, 64'(perr), 64'(old_pe));
    if (id) check_tail(tag, LRST_N);
  endtask

  initial begin
    rst_n = 1'b0; start = 0; rnw = 0; apndp = 0; addr = 0; wdata = 0;
    lrst = 0; idle = 0; tgt_ack = 0; tgt_data = 0; tgt_rd = 0; tgt_flip = 0;
    repeat (4) @(negedge clk);
    chk("R11 reset state", 64'({busy, done, oe, swclk, perr}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_read ("rd_ok",    1'b0, 2'd1, 32'hA5C3_1E07, 3'b001, 1'b0, 1'b0, 1'b0);
    test_read ("rd_badpar",1'b1, 2'd3, 32'h0000_0001, 3'b010, 1'b1, 1'b0, 1'b0);
    test_write("wr_one",   1'b1, 2'd2, 32'h8123_4567, 3'b100, 1'b0);
    test_write("wr_zero",  1'b0, 2'd0, 32'hFFFF_FFFE, 3'b001, 1'b1);
    test_read ("rd_junk",  1'b1, 2'd0, 32'h7FFF_0000, 3'b111, 1'b0, 1'b1, 1'b0);
    test_lrst ("lrst_idle", 1'b1);
    test_lrst ("lrst",      1'b0);
    test_read ("rd_bump",  1'b0, 2'd2, 32'h1357_9BDF, 3'b000, 1'b0, 1'b0, 1'b1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R11 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule